// File: doc/BRIEF.md
# Interrupt Arbiter with Wake-up Control

This block collects a set of maskable interrupt request lines and one high-priority "X" request. It selects the request that wins and forms that request's vector address from a programmable table base. It then raises a registered interrupt to the processor, and the request and vector stay frozen until the processor acknowledges.

The processor reports two mask bits and its operating mode (run, wait or stop). The I bit gates the maskable sources. The X bit gates only whether the X handler is entered.

Outside run mode nothing is taken, but the block drives a wake-up output. In wait mode that output is registered. In stop mode it is combinational, so it works without a clock, and only sources marked as asynchronous can raise it. An X request wakes the part even when the X bit is set. In that case the block tells the processor to resume after the sleep instruction instead of entering a handler.

Top module: `irq_arbiter_wake`

## Requirements
- R1: After reset, no interrupt is pending, wake-up and resume are low, and the table base is 0xFF80.
- R2: In run mode, with the I bit clear and the X request not winning, the highest-indexed asserted request line wins. Its vector is base + 2*index, and it appears with the interrupt one clock after the request is sampled.
- R3: While the I bit is set, no maskable request is taken.
- R4: An X request with the X bit clear wins over every maskable request, even while the I bit is set. Its vector is base + 2*N_SRC (0xFF90 by default).
- R5: An X request with the X bit set is never taken, and maskable arbitration proceeds as if it were absent.
- R6: A write to the base register relocates the vectors of every interrupt taken after the write's clock edge.
- R7: Once raised, the interrupt and its vector hold unchanged until the acknowledge is sampled high. The interrupt then falls at that same edge, and a new take can happen at the next edge.
- R8: Nothing is taken in wait (mode 2'b01) or stop (mode 2'b1x); run is mode 2'b00.
- R9: In wait mode, wake-up rises one clock after an X request or an unmasked maskable request appears. With the I bit set, maskable requests do not raise it.
- R10: In stop mode, wake-up follows the inputs with no clock. Only the X request or an asynchronous-capable maskable line (ASYNC_MASK, default lines 0 to 3) with the I bit clear raises it.
- R11: The resume-next output is high, combinationally, whenever the mode is not run and the X request is asserted with the X bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Write strobe for the vector table base |
| base_wdata | input | ADDR_W | New vector table base |
| req_i | input | N_SRC | Maskable request lines, index = priority |
| xreq_i | input | 1 | X request |
| cpu_ibit | input | 1 | Processor I mask bit |
| cpu_xbit | input | 1 | Processor X mask bit |
| cpu_mode | input | 2 | 00 run, 01 wait, 1x stop |
| irq_ack | input | 1 | Acknowledge pulse from the processor |
| irq_o | output | 1 | Registered interrupt to the processor |
| vec_o | output | ADDR_W | Vector address of the taken interrupt |
| wake_o | output | 1 | Wake-up request |
| resume_next_o | output | 1 | X wake-up while masked: resume without a handler |

## Verification
Arbitration is tried with single lines and with lines at both ends of the index range asserted together, which separates lowest-wins from highest-wins. X is applied together with maskable lines under each combination of the two mask bits, so that its priority, its bypass of the I bit and its suppression by the X bit can be told apart. Stability is checked by changing the requests while an interrupt is held. Wake-up is probed in wait mode just before and just after an edge, which separates a registered path from a combinational one. In stop mode it is probed with no edge at all, using synchronous-only and asynchronous-capable lines to distinguish the two classes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_WAIT = 2'b01,
        MODE_STOP = 2'b10
    } cpu_mode_e;

    function automatic logic is_stop(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic is_wait(input logic [1:0] m);
        return (m == MODE_WAIT);
    endfunction

    function automatic logic is_run(input logic [1:0] m);
        return (m == MODE_RUN);
    endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Later (higher) indices overwrite earlier ones: highest index wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_wake_unit.sv
module irq_wake_unit
    import irq_arb_pkg::*;
#(
    parameter int               N_SRC      = 8,
    parameter logic [N_SRC-1:0] ASYNC_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             xreq_i,
    input  logic             cpu_ibit,
    input  logic             cpu_xbit,
    input  logic [1:0]       cpu_mode,
    output logic             wake_o,
    output logic             resume_next_o
);
    logic wait_wake_d, wait_wake_q;
    logic i_qual, i_async_qual, stop_wake;

    always_comb begin
        i_qual       = (|req_i) & ~cpu_ibit;
        i_async_qual = (|(req_i & ASYNC_MASK)) & ~cpu_ibit;
        stop_wake    = xreq_i | i_async_qual;
        wait_wake_d  = is_wait(cpu_mode) & (xreq_i | i_qual);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_wake_q <= 1'b0;
        else        wait_wake_q <= wait_wake_d;
    end

    assign wake_o        = is_stop(cpu_mode) ? stop_wake : wait_wake_q;
    assign resume_next_o = ~is_run(cpu_mode) & xreq_i & cpu_xbit;

    // R10: in stop mode a synchronous-only line never wakes the part
    p_stop_async_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stop(cpu_mode) && !xreq_i && ((req_i & ASYNC_MASK) == '0)) |-> !wake_o);
    // R9: I-masked wait with no X request gives no wake one cycle later
    p_wait_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wait(cpu_mode) && cpu_ibit && !xreq_i) |=> (!is_wait(cpu_mode) || !wake_o || $past(!cpu_ibit)));
    // R11: resume flag never raised in run mode
    p_resume_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_run(cpu_mode) |-> !resume_next_o);
endmodule

// File: rtl/irq_arbiter_wake.sv
module irq_arbiter_wake
    import irq_arb_pkg::*;
#(
    parameter int                N_SRC        = 8,
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] DEFAULT_BASE = 16'hFF80,
    parameter logic [N_SRC-1:0]  ASYNC_MASK   = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic [N_SRC-1:0]  req_i,
    input  logic              xreq_i,
    input  logic              cpu_ibit,
    input  logic              cpu_xbit,
    input  logic [1:0]        cpu_mode,
    input  logic              irq_ack,
    output logic              irq_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic              wake_o,
    output logic              resume_next_o
);
    localparam int                IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [ADDR_W-1:0] X_OFS = ADDR_W'(2 * N_SRC);

    typedef struct packed {
        logic              irq;
        logic              xsel;
        logic [ADDR_W-1:0] vec;
        logic [ADDR_W-1:0] base;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic             i_hit;
    logic [IDX_W-1:0] i_idx;
    logic             x_win;

    irq_prio_enc #(.N(N_SRC), .IDX_W(IDX_W)) u_enc (
        .req (req_i & {N_SRC{~cpu_ibit}}),
        .hit (i_hit),
        .idx (i_idx)
    );

    irq_wake_unit #(.N_SRC(N_SRC), .ASYNC_MASK(ASYNC_MASK)) u_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .xreq_i        (xreq_i),
        .cpu_ibit      (cpu_ibit),
        .cpu_xbit      (cpu_xbit),
        .cpu_mode      (cpu_mode),
        .wake_o        (wake_o),
        .resume_next_o (resume_next_o)
    );

    always_comb begin
        st_d  = st_q;
        x_win = xreq_i & ~cpu_xbit;
        if (base_we) st_d.base = base_wdata;
        if (st_q.irq) begin
            if (irq_ack) st_d.irq = 1'b0;
        end else if (is_run(cpu_mode)) begin
            if (x_win) begin
                st_d.irq  = 1'b1;
                st_d.xsel = 1'b1;
                st_d.vec  = st_q.base + X_OFS;
            end else if (i_hit) begin
                st_d.irq  = 1'b1;
                st_d.xsel = 1'b0;
                st_d.vec  = st_q.base + ADDR_W'({i_idx, 1'b0});
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq  <= 1'b0;
            st_q.xsel <= 1'b0;
            st_q.vec  <= '0;
            st_q.base <= DEFAULT_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
    assign vec_o = st_q.vec;

    // R7: held until acknowledged
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_ack) |=> (irq_o && $stable(vec_o)));
    // R7: acknowledge drops the interrupt
    p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_ack) |=> !irq_o);
    // R8: takes only happen from run mode
    p_run_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(is_run(cpu_mode)));
    // R5: an X take needs a clear X bit
    p_xmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && st_q.xsel) |-> $past(xreq_i && !cpu_xbit));
    // R3: a maskable take needs a clear I bit
    p_imask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && !st_q.xsel) |-> $past(!cpu_ibit && (req_i != '0)));
endmodule

// File: tb/sim_irq_arbiter_wake.sv
module sim_irq_arbiter_wake;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [15:0] base_wdata = '0;
    logic [7:0]  req_i = '0;
    logic        xreq_i = 1'b0, cpu_ibit = 1'b0, cpu_xbit = 1'b0, irq_ack = 1'b0;
    logic [1:0]  cpu_mode = 2'b00;
    logic        irq_o, wake_o, resume_next_o;
    logic [15:0] vec_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_arbiter_wake u0 (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_i(req_i), .xreq_i(xreq_i), .cpu_ibit(cpu_ibit), .cpu_xbit(cpu_xbit),
        .cpu_mode(cpu_mode), .irq_ack(irq_ack), .irq_o(irq_o), .vec_o(vec_o),
        .wake_o(wake_o), .resume_next_o(resume_next_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic drv(input logic [7:0] r, input logic x, input logic ib, input logic xb);
        @(negedge clk);
        req_i = r; xreq_i = x; cpu_ibit = ib; cpu_xbit = xb;
    endtask

    task automatic ack_clear();
        @(negedge clk);
        req_i = '0; xreq_i = 1'b0; irq_ack = irq_o;
        step();
        irq_ack = 1'b0;
    endtask

    // {req[7:0], xreq, ibit, xbit, exp_irq, exp_vec[15:0]}, base 0xFF80
    localparam logic [27:0] TBL [8] = '{
        {8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFF80},  // R2 single low line
        {8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFF8E},  // R2 both ends: high wins
        {8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFF84},  // R2 middle pair
        {8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},  // R3 all masked
        {8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFF90},  // R4 X beats line 4
        {8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFF90},  // R4 X while I set
        {8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000},  // R5 X masked alone
        {8'h08, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFF86}   // R5 X masked, line 3 wins
    };

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq after reset", irq_o, 0);
        chk("R1 wake after reset", wake_o, 0);
        chk("R1 resume after reset", resume_next_o, 0);
        @(negedge clk); rst_n = 1'b1;
        step();

        for (int k = 0; k < 8; k++) begin
            drv(TBL[k][27:20], TBL[k][19], TBL[k][18], TBL[k][17]);
            step();
            chk($sformatf("R2-table%0d irq", k), irq_o, TBL[k][16]);
            if (TBL[k][16]) chk($sformatf("R1 R2 table%0d vec", k), vec_o, TBL[k][15:0]);
            ack_clear();
            chk($sformatf("R7 table%0d cleared", k), irq_o, 0);
        end

        // R7 hold and re-arbitrate
        drv(8'h02, 0, 0, 0);
        step();
        chk("R7 take", vec_o, 16'hFF82);
        @(negedge clk); req_i = 8'h80;
        repeat (3) step();
        chk("R7 hold irq", irq_o, 1);
        chk("R7 hold vec", vec_o, 16'hFF82);
        @(negedge clk); irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R7 drop on ack", irq_o, 0);
        step();
        chk("R7 retake vec", vec_o, 16'hFF8E);
        ack_clear();

        // R6 relocation
        @(negedge clk); base_we = 1'b1; base_wdata = 16'h1200;
        step();
        base_we = 1'b0;
        drv(8'h04, 0, 0, 0);
        step();
        chk("R6 relocated vec", vec_o, 16'h1204);
        ack_clear();
        drv(8'h00, 1, 1, 0);
        step();
        chk("R6 relocated X vec", vec_o, 16'h1210);
        ack_clear();

        // R8 / R9 wait mode
        @(negedge clk); cpu_mode = 2'b01;
        drv(8'h01, 0, 0, 0);
        #1 chk("R9 wake not yet (registered)", wake_o, 0);
        step();
        chk("R9 wake in wait", wake_o, 1);
        step();
        chk("R8 no take in wait", irq_o, 0);
        drv(8'h01, 0, 1, 0);
        step();
        chk("R9 I set blocks wake", wake_o, 0);
        drv(8'h00, 1, 1, 1);
        #1 chk("R11 resume in wait", resume_next_o, 1);
        step();
        chk("R9 X wakes despite X bit", wake_o, 1);
        chk("R8 masked X not taken", irq_o, 0);

        // R10 stop mode, no clock edge needed
        @(negedge clk); cpu_mode = 2'b10; xreq_i = 0; cpu_xbit = 0; cpu_ibit = 0; req_i = 8'h10;
        #1 chk("R10 sync line no wake", wake_o, 0);
        req_i = 8'h01;
        #1 chk("R10 async line wakes", wake_o, 1);
        cpu_ibit = 1;
        #1 chk("R10 I set blocks async", wake_o, 0);
        req_i = 8'h00; xreq_i = 1; cpu_xbit = 1;
        #1 chk("R10 X wakes in stop", wake_o, 1);
        chk("R11 resume in stop", resume_next_o, 1);
        cpu_xbit = 0;
        #1 chk("R11 no resume with X clear", resume_next_o, 0);
        cpu_mode = 2'b00; cpu_xbit = 1;
        #1 chk("R11 no resume in run", resume_next_o, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule